// File: doc/BRIEF.md
# Keyboard/Auxiliary Controller Host Register Block

This block is the byte-wide host side of a legacy keyboard and pointing-device controller. The host sees two locations. Offset 1 reads a status byte and, when written, takes a controller command. Offset 0 is the data location. Reads at offset 0 pop the byte waiting for the host. Writes at offset 0 are steered by whichever data-write command was last issued.

Inside the block are a mode byte, a status byte, an output-port byte, and two one-deep holding registers. One holding register serves the keyboard side and one serves the auxiliary side. Bytes reach these registers from the two device sources through plain valid/data inputs. Bytes also arrive from the controller itself, as command replies and as host-forced loads. The block raises registered keyboard and auxiliary interrupt levels. It also drives the A20 gate level, a one-cycle system-reset request, and byte-wide write strobes towards the keyboard and auxiliary devices. Serial line timing and scan-code translation are outside this block; only the translation enable is brought out.

Top module: `kbc_host_if`

## Requirements
- R1: After reset the status byte reads 0x18, the mode byte reads 0x03, the output port reads 0xCF, A20 is 1, and both interrupts, the reset request and the translation enable are 0.
- R2: Command 0x20 places the mode byte in the keyboard holding register. 0xD0 places the output port there. 0xC0 places 0x80 there. 0xA9 and 0xAB each place 0x00 there. 0xAA places 0x55 there and sets status bit 2 for good.
- R3: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 arm a one-shot target for the next offset-0 write. The targets are, in that order: the mode byte, the output port, the keyboard holding register, the auxiliary holding register, and the auxiliary device strobe. With nothing armed, an offset-0 write drives the keyboard device strobe. Each offset-0 write disarms the target.
- R4: Status bit 0 is 1 while either holding register is full. Bit 5 is 1 only when the auxiliary register alone is full. Bit 1 always reads 0. Bit 3 is set by a write to offset 1 and cleared by a write to offset 0. Bit 4 always reads 1. Bits 7 and 6 always read 0.
- R5: An offset-0 read returns, and empties, the auxiliary register when it alone is full; otherwise it returns and empties the keyboard register.
- R6: The interrupts update one cycle after the state they depend on. The auxiliary interrupt is high when the auxiliary register alone is full and mode bit 1 is set. The keyboard interrupt is high when some other byte is held, mode bit 0 is set and mode bit 4 is clear.
- R7: Command 0xAD sets mode bit 4 and 0xAE clears it. 0xA7 sets mode bit 5 and 0xA8 clears it. The translation enable output follows mode bit 6.
- R8: Command 0xDF sets A20 and output-port bit 1; 0xDD clears both. An output-port write takes A20 from data bit 1.
- R9: A command with upper nibble 0xF and bit 0 clear, or an output-port write with data bit 0 clear, gives a one-cycle reset request on the next cycle. Such a command with bit 0 set does nothing.
- R10: Output-port bits 4 and 5 reflect the same buffer conditions as status bits 0 and 5. All other output-port bits hold the last written value.
- R11: An unlisted command byte changes nothing apart from status bit 3.
- R12: A source byte arriving while its register stays full is dropped. A controller-made byte (reply or forced load) wins over a source byte in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (pops on offset 0) |
| host_addr | input | 1 | 0 = data location, 1 = command/status location |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (combinational) |
| kbd_rx_valid | input | 1 | Keyboard source byte valid |
| kbd_rx_data | input | 8 | Keyboard source byte |
| aux_rx_valid | input | 1 | Auxiliary source byte valid |
| aux_rx_data | input | 8 | Auxiliary source byte |
| kbd_dev_wr | output | 1 | One-cycle strobe: byte for the keyboard device |
| kbd_dev_data | output | 8 | Byte for the keyboard device |
| aux_dev_wr | output | 1 | One-cycle strobe: byte for the auxiliary device |
| aux_dev_data | output | 8 | Byte for the auxiliary device |
| kbd_irq | output | 1 | Keyboard interrupt level |
| aux_irq | output | 1 | Auxiliary interrupt level |
| a20_out | output | 1 | A20 gate level |
| sys_reset | output | 1 | One-cycle system reset request |
| kbd_xlate | output | 1 | Scan-code translation enable |

## Verification
Some rules are checked on every cycle. The input-buffer-full bit must stay low, and the two interrupts must never both be high. Each interrupt must follow a status condition from the cycle before. A20 changes and reset requests may only follow a host write, and the two device strobes must never fire together. The bench scenarios are needed for the rest. These are the reply values and where each armed write lands, the keyboard-first read order, dropped and colliding bytes, and the even/odd split of the pulse commands.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

   typedef enum logic [2:0] {
      PW_NONE, PW_MODE, PW_OUTP, PW_KBUF, PW_ABUF, PW_AUXDEV
   } pw_e;

   typedef enum logic [1:0] {RS_CONST, RS_MODE, RS_OUTP} rsel_e;

   typedef struct packed {
      logic       arm;
      pw_e        pw;
      logic       reply_v;
      rsel_e      rsel;
      logic [7:0] reply_const;
      logic       selftest;
      logic       kdis_set;
      logic       kdis_clr;
      logic       adis_set;
      logic       adis_clr;
      logic       a20_set;
      logic       a20_clr;
      logic       rst_req;
   } cmd_t;

   localparam logic [7:0] C_RD_MODE  = 8'h20;
   localparam logic [7:0] C_WR_MODE  = 8'h60;
   localparam logic [7:0] C_AUX_OFF  = 8'hA7;
   localparam logic [7:0] C_AUX_ON   = 8'hA8;
   localparam logic [7:0] C_AUX_TEST = 8'hA9;
   localparam logic [7:0] C_SELFTEST = 8'hAA;
   localparam logic [7:0] C_KBD_TEST = 8'hAB;
   localparam logic [7:0] C_KBD_OFF  = 8'hAD;
   localparam logic [7:0] C_KBD_ON   = 8'hAE;
   localparam logic [7:0] C_RD_IN    = 8'hC0;
   localparam logic [7:0] C_RD_OUT   = 8'hD0;
   localparam logic [7:0] C_WR_OUT   = 8'hD1;
   localparam logic [7:0] C_WR_KBUF  = 8'hD2;
   localparam logic [7:0] C_WR_ABUF  = 8'hD3;
   localparam logic [7:0] C_WR_AUX   = 8'hD4;
   localparam logic [7:0] C_A20_OFF  = 8'hDD;
   localparam logic [7:0] C_A20_ON   = 8'hDF;

   localparam int M_KIRQ = 0;
   localparam int M_AIRQ = 1;
   localparam int M_KDIS = 4;
   localparam int M_ADIS = 5;
   localparam int M_XLAT = 6;

endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
   import kbc_pkg::*;
#(
   parameter logic [7:0] SELFTEST_BYTE = 8'h55,
   parameter logic [7:0] TEST_OK_BYTE  = 8'h00,
   parameter logic [7:0] INPORT_BYTE   = 8'h80
) (
   input  logic [7:0] cmd,
   output cmd_t       dec
);

   always_comb begin
      dec      = '0;
      dec.pw   = PW_NONE;
      dec.rsel = RS_CONST;
      if (cmd[7:4] == 4'hF) begin
         dec.rst_req = ~cmd[0];
      end else begin
         case (cmd)
            C_RD_MODE:  begin dec.reply_v = 1'b1; dec.rsel = RS_MODE; end
            C_RD_OUT:   begin dec.reply_v = 1'b1; dec.rsel = RS_OUTP; end
            C_RD_IN:    begin dec.reply_v = 1'b1; dec.reply_const = INPORT_BYTE; end
            C_AUX_TEST,
            C_KBD_TEST: begin dec.reply_v = 1'b1; dec.reply_const = TEST_OK_BYTE; end
            C_SELFTEST: begin
               dec.reply_v     = 1'b1;
               dec.reply_const = SELFTEST_BYTE;
               dec.selftest    = 1'b1;
            end
            C_WR_MODE:  begin dec.arm = 1'b1; dec.pw = PW_MODE;   end
            C_WR_OUT:   begin dec.arm = 1'b1; dec.pw = PW_OUTP;   end
            C_WR_KBUF:  begin dec.arm = 1'b1; dec.pw = PW_KBUF;   end
            C_WR_ABUF:  begin dec.arm = 1'b1; dec.pw = PW_ABUF;   end
            C_WR_AUX:   begin dec.arm = 1'b1; dec.pw = PW_AUXDEV; end
            C_AUX_OFF:  dec.adis_set = 1'b1;
            C_AUX_ON:   dec.adis_clr = 1'b1;
            C_KBD_OFF:  dec.kdis_set = 1'b1;
            C_KBD_ON:   dec.kdis_clr = 1'b1;
            C_A20_ON:   dec.a20_set  = 1'b1;
            C_A20_OFF:  dec.a20_clr  = 1'b1;
            default:    ;
         endcase
      end
   end

endmodule

// File: rtl/kbc_obuf.sv
module kbc_obuf #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctl_ld,
   input  logic [DW-1:0] ctl_byte,
   input  logic          src_ld,
   input  logic [DW-1:0] src_byte,
   input  logic          pop,
   output logic          full,
   output logic [DW-1:0] byte_q
);

   logic room;
   assign room = ~full | pop;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full   <= 1'b0;
         byte_q <= '0;
      end else if (ctl_ld) begin
         full   <= 1'b1;
         byte_q <= ctl_byte;
      end else if (src_ld && room) begin
         full   <= 1'b1;
         byte_q <= src_byte;
      end else if (pop) begin
         full   <= 1'b0;
      end
   end

endmodule

// File: rtl/kbc_irq.sv
module kbc_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic kbd_full,
   input  logic aux_full,
   input  logic kirq_en,
   input  logic airq_en,
   input  logic kbd_off,
   output logic kbd_irq,
   output logic aux_irq
);

   logic aux_alone;
   assign aux_alone = aux_full & ~kbd_full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kbd_irq <= 1'b0;
         aux_irq <= 1'b0;
      end else begin
         kbd_irq <= kbd_full & kirq_en & ~kbd_off;
         aux_irq <= aux_alone & airq_en;
      end
   end

endmodule

// File: rtl/kbc_host_if.sv
module kbc_host_if
   import kbc_pkg::*;
#(
   parameter int         DW            = 8,
   parameter logic [7:0] MODE_RST      = 8'h03,
   parameter logic [7:0] OUTP_RST      = 8'hCF,
   parameter logic [7:0] SELFTEST_BYTE = 8'h55,
   parameter logic [7:0] TEST_OK_BYTE  = 8'h00,
   parameter logic [7:0] INPORT_BYTE   = 8'h80
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_wr,
   input  logic          host_rd,
   input  logic          host_addr,
   input  logic [DW-1:0] host_wdata,
   output logic [DW-1:0] host_rdata,
   input  logic          kbd_rx_valid,
   input  logic [DW-1:0] kbd_rx_data,
   input  logic          aux_rx_valid,
   input  logic [DW-1:0] aux_rx_data,
   output logic          kbd_dev_wr,
   output logic [DW-1:0] kbd_dev_data,
   output logic          aux_dev_wr,
   output logic [DW-1:0] aux_dev_data,
   output logic          kbd_irq,
   output logic          aux_irq,
   output logic          a20_out,
   output logic          sys_reset,
   output logic          kbd_xlate
);

   localparam int NCH    = 2;
   localparam int CH_KBD = 0;
   localparam int CH_AUX = 1;

   if (DW != 8) begin : g_bad_width
      $error("kbc_host_if: DW must be 8");
   end
   if (OUTP_RST[0] != 1'b1) begin : g_bad_outp
      $error("kbc_host_if: OUTP_RST bit 0 must be 1");
   end

   cmd_t dec;
   logic cmd_wr, dat_wr, dat_rd, any_full, aux_alone;
   logic [DW-1:0] mode_q, status_byte, outp_view, reply;
   logic [1:0] op_hi_q;
   logic [3:0] op_lo_q;
   logic selftest_q, cmd_flag_q, sys_reset_q;
   pw_e pw_q;

   logic [NCH-1:0] ctl_ld, src_ld, pop, full;
   logic [DW-1:0]  ctl_b [NCH];
   logic [DW-1:0]  src_b [NCH];
   logic [DW-1:0]  buf_q [NCH];

   kbc_cmd_decode #(
      .SELFTEST_BYTE (SELFTEST_BYTE),
      .TEST_OK_BYTE  (TEST_OK_BYTE),
      .INPORT_BYTE   (INPORT_BYTE)
   ) u_dec (
      .cmd (host_wdata),
      .dec (dec)
   );

   for (genvar ch = 0; ch < NCH; ch++) begin : g_obuf
      kbc_obuf #(.DW(DW)) u_obuf (
         .clk      (clk),
         .rst_n    (rst_n),
         .ctl_ld   (ctl_ld[ch]),
         .ctl_byte (ctl_b[ch]),
         .src_ld   (src_ld[ch]),
         .src_byte (src_b[ch]),
         .pop      (pop[ch]),
         .full     (full[ch]),
         .byte_q   (buf_q[ch])
      );
   end

   always_comb begin
      cmd_wr    = host_wr & host_addr;
      dat_wr    = host_wr & ~host_addr;
      dat_rd    = host_rd & ~host_addr;
      any_full  = |full;
      aux_alone = full[CH_AUX] & ~full[CH_KBD];

      status_byte = {2'b00, aux_alone, 1'b1, cmd_flag_q, selftest_q, 1'b0, any_full};
      outp_view   = {op_hi_q, aux_alone, any_full, op_lo_q};

      case (dec.rsel)
         RS_MODE: reply = mode_q;
         RS_OUTP: reply = outp_view;
         default: reply = dec.reply_const;
      endcase

      ctl_ld[CH_KBD] = (cmd_wr & dec.reply_v) | (dat_wr & (pw_q == PW_KBUF));
      ctl_b[CH_KBD]  = cmd_wr ? reply : host_wdata;
      ctl_ld[CH_AUX] = dat_wr & (pw_q == PW_ABUF);
      ctl_b[CH_AUX]  = host_wdata;

      src_ld[CH_KBD] = kbd_rx_valid;
      src_b[CH_KBD]  = kbd_rx_data;
      src_ld[CH_AUX] = aux_rx_valid;
      src_b[CH_AUX]  = aux_rx_data;

      pop[CH_AUX] = dat_rd & aux_alone;
      pop[CH_KBD] = dat_rd & ~aux_alone;

      host_rdata = host_addr ? status_byte
                 : (aux_alone ? buf_q[CH_AUX] : buf_q[CH_KBD]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q       <= MODE_RST;
         op_hi_q      <= OUTP_RST[7:6];
         op_lo_q      <= OUTP_RST[3:0];
         selftest_q   <= 1'b0;
         cmd_flag_q   <= 1'b1;
         pw_q         <= PW_NONE;
         sys_reset_q  <= 1'b0;
         kbd_dev_wr   <= 1'b0;
         kbd_dev_data <= '0;
         aux_dev_wr   <= 1'b0;
         aux_dev_data <= '0;
      end else begin
         sys_reset_q <= 1'b0;
         kbd_dev_wr  <= 1'b0;
         aux_dev_wr  <= 1'b0;
         if (cmd_wr) begin
            cmd_flag_q <= 1'b1;
            if (dec.arm)      pw_q       <= dec.pw;
            if (dec.selftest) selftest_q <= 1'b1;
            if (dec.kdis_set) mode_q[M_KDIS] <= 1'b1;
            if (dec.kdis_clr) mode_q[M_KDIS] <= 1'b0;
            if (dec.adis_set) mode_q[M_ADIS] <= 1'b1;
            if (dec.adis_clr) mode_q[M_ADIS] <= 1'b0;
            if (dec.a20_set)  op_lo_q[1] <= 1'b1;
            if (dec.a20_clr)  op_lo_q[1] <= 1'b0;
            sys_reset_q <= dec.rst_req;
         end
         if (dat_wr) begin
            cmd_flag_q <= 1'b0;
            pw_q       <= PW_NONE;
            case (pw_q)
               PW_NONE: begin
                  kbd_dev_wr   <= 1'b1;
                  kbd_dev_data <= host_wdata;
               end
               PW_MODE: mode_q <= host_wdata;
               PW_OUTP: begin
                  op_hi_q     <= host_wdata[7:6];
                  op_lo_q     <= host_wdata[3:0];
                  sys_reset_q <= ~host_wdata[0];
               end
               PW_AUXDEV: begin
                  aux_dev_wr   <= 1'b1;
                  aux_dev_data <= host_wdata;
               end
               default: ;
            endcase
         end
      end
   end

   kbc_irq u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .kbd_full (full[CH_KBD]),
      .aux_full (full[CH_AUX]),
      .kirq_en  (mode_q[M_KIRQ]),
      .airq_en  (mode_q[M_AIRQ]),
      .kbd_off  (mode_q[M_KDIS]),
      .kbd_irq  (kbd_irq),
      .aux_irq  (aux_irq)
   );

   assign a20_out   = op_lo_q[1];
   assign sys_reset = sys_reset_q;
   assign kbd_xlate = mode_q[M_XLAT];

endmodule

// File: rtl/kbc_host_if_chk.sv
module kbc_host_if_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       host_wr,
   input logic       host_addr,
   input logic [7:0] status,
   input logic       kbd_irq,
   input logic       aux_irq,
   input logic       a20_out,
   input logic       sys_reset,
   input logic       kbd_dev_wr,
   input logic       aux_dev_wr
);

   p_ibf_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      status[1] == 1'b0);

   p_cmd_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_addr) |=> status[3]);

   p_irq_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(kbd_irq && aux_irq));

   p_aux_irq_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      aux_irq |-> $past(status[5]));

   p_kbd_irq_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      kbd_irq |-> $past(status[0] && !status[5]));

   p_a20_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(a20_out) |-> $past(host_wr));

   p_rst_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sys_reset |-> $past(host_wr));

   p_dev_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(kbd_dev_wr && aux_dev_wr));

endmodule

bind kbc_host_if kbc_host_if_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_wr    (host_wr),
   .host_addr  (host_addr),
   .status     (status_byte),
   .kbd_irq    (kbd_irq),
   .aux_irq    (aux_irq),
   .a20_out    (a20_out),
   .sys_reset  (sys_reset),
   .kbd_dev_wr (kbd_dev_wr),
   .aux_dev_wr (aux_dev_wr)
);

// File: tb/kbc_host_if_tb.sv
`timescale 1ns/1ps
module kbc_host_if_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_wr = 1'b0, host_rd = 1'b0, host_addr = 1'b0;
   logic [7:0] host_wdata = '0, host_rdata;
   logic       kbd_rx_valid = 1'b0, aux_rx_valid = 1'b0;
   logic [7:0] kbd_rx_data = '0, aux_rx_data = '0;
   logic       kbd_dev_wr, aux_dev_wr, kbd_irq, aux_irq, a20_out, sys_reset, kbd_xlate;
   logic [7:0] kbd_dev_data, aux_dev_data;

   int nchk = 0;
   int nerr = 0;
   logic selft = 1'b0;
   logic cmdf  = 1'b1;
   logic [7:0] v;

   always #2.5 clk = ~clk;

   kbc_host_if u_dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .kbd_rx_valid(kbd_rx_valid), .kbd_rx_data(kbd_rx_data),
      .aux_rx_valid(aux_rx_valid), .aux_rx_data(aux_rx_data),
      .kbd_dev_wr(kbd_dev_wr), .kbd_dev_data(kbd_dev_data),
      .aux_dev_wr(aux_dev_wr), .aux_dev_data(aux_dev_data),
      .kbd_irq(kbd_irq), .aux_irq(aux_irq), .a20_out(a20_out),
      .sys_reset(sys_reset), .kbd_xlate(kbd_xlate)
   );

   // command byte in [15:8], expected reply in [7:0] (R2)
   localparam logic [15:0] VEC [0:5] = '{
      16'h2003, 16'hC080, 16'hA900, 16'hAB00, 16'hD0CF, 16'hAA55
   };

   function automatic logic [7:0] exp_st(input logic kf, input logic af);
      return {2'b00, af & ~kf, 1'b1, cmdf, selft, 1'b0, kf | af};
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      tick();
      host_wr = 1'b0;
      cmdf = a;
   endtask

   task automatic rd_data(output logic [7:0] d);
      host_rd = 1'b1; host_addr = 1'b0;
      #1 d = host_rdata;
      @(posedge clk); @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic rd_st(output logic [7:0] d);
      host_addr = 1'b1;
      #1 d = host_rdata;
   endtask

   task automatic src(input logic kv, input logic [7:0] kd, input logic av, input logic [7:0] ad);
      kbd_rx_valid = kv; kbd_rx_data = kd; aux_rx_valid = av; aux_rx_data = ad;
      tick();
      kbd_rx_valid = 1'b0; aux_rx_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd_st(v); chk("R1 status", v, 8'h18);
      chk("R1 irqs/a20/rst/xlate", {3'b0, kbd_irq, aux_irq, a20_out, sys_reset, kbd_xlate}, 8'h04);

      // R2 reply table (also R1 mode/output-port reset values via 0x20/0xD0)
      for (int i = 0; i < 6; i++) begin
         wr(1'b1, VEC[i][15:8]);
         if (VEC[i][15:8] == 8'hAA) selft = 1'b1;
         rd_st(v); chk("R2 status after cmd", v, exp_st(1'b1, 1'b0));
         rd_data(v); chk($sformatf("R2 reply to %02h", VEC[i][15:8]), v, VEC[i][7:0]);
         rd_st(v); chk("R5 empty after read", v, exp_st(1'b0, 1'b0));
      end

      // R3 mode target, R7 translation
      wr(1'b1, 8'h60); wr(1'b0, 8'h47);
      chk("R4 data write clears bit3", exp_st(0,0), {2'b00,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0});
      chk("R7 xlate on", {7'b0, kbd_xlate}, 8'h01);
      wr(1'b1, 8'h20); rd_data(v); chk("R3 mode write", v, 8'h47);
      wr(1'b1, 8'h60); wr(1'b0, 8'h03);
      chk("R7 xlate off", {7'b0, kbd_xlate}, 8'h00);

      // R3 forced keyboard / auxiliary loads
      wr(1'b1, 8'hD2); wr(1'b0, 8'h5A);
      rd_st(v); chk("R4 kbd held", v, exp_st(1'b1, 1'b0));
      rd_data(v); chk("R3 kbd forced", v, 8'h5A);
      wr(1'b1, 8'hD3); wr(1'b0, 8'h66);
      rd_st(v); chk("R4 aux alone", v, exp_st(1'b0, 1'b1));
      wr(1'b1, 8'hD0); rd_data(v); chk("R10 outport with buffers", v, 8'hFF);
      rd_data(v); chk("R5 aux byte", v, 8'h66);

      // R3 device targets
      wr(1'b1, 8'hD4); wr(1'b0, 8'h77);
      chk("R3 aux dev strobe", {aux_dev_wr, kbd_dev_wr, 6'b0}, 8'h80);
      chk("R3 aux dev data", aux_dev_data, 8'h77);
      wr(1'b0, 8'h99);
      chk("R3 kbd dev strobe", {aux_dev_wr, kbd_dev_wr, 6'b0}, 8'h40);
      chk("R3 kbd dev data", kbd_dev_data, 8'h99);

      // R6 interrupts
      src(1'b1, 8'h50, 1'b0, 8'h00);
      chk("R6 irq lags one cycle", {7'b0, kbd_irq}, 8'h00);
      tick(); chk("R6 kbd irq", {6'b0, kbd_irq, aux_irq}, 8'h02);
      wr(1'b1, 8'hAD); tick(); chk("R6 R7 kbd disabled", {6'b0, kbd_irq, aux_irq}, 8'h00);
      wr(1'b1, 8'hAE); tick(); chk("R6 R7 kbd enabled", {6'b0, kbd_irq, aux_irq}, 8'h02);
      rd_data(v); chk("R6 kbd byte", v, 8'h50);
      tick(); chk("R6 irq after pop", {6'b0, kbd_irq, aux_irq}, 8'h00);
      wr(1'b1, 8'h60); wr(1'b0, 8'h02);
      src(1'b1, 8'h51, 1'b0, 8'h00); tick();
      chk("R6 mode bit0 off", {6'b0, kbd_irq, aux_irq}, 8'h00);
      rd_data(v);
      wr(1'b1, 8'h60); wr(1'b0, 8'h03);
      src(1'b0, 8'h00, 1'b1, 8'h61); tick();
      chk("R6 aux irq", {6'b0, kbd_irq, aux_irq}, 8'h01);
      rd_data(v); chk("R5 aux source byte", v, 8'h61);

      // R5 keyboard first
      src(1'b1, 8'h41, 1'b1, 8'h42);
      rd_st(v); chk("R4 both held", v, exp_st(1'b1, 1'b1));
      rd_data(v); chk("R5 kbd first", v, 8'h41);
      rd_data(v); chk("R5 aux second", v, 8'h42);

      // R7 aux disable bit
      wr(1'b1, 8'hA7); wr(1'b1, 8'h20); rd_data(v); chk("R7 aux off", v, 8'h23);
      wr(1'b1, 8'hA8); wr(1'b1, 8'h20); rd_data(v); chk("R7 aux on", v, 8'h03);

      // R8 A20
      wr(1'b1, 8'hDD); chk("R8 A20 off", {7'b0, a20_out}, 8'h00);
      wr(1'b1, 8'hDF); chk("R8 A20 on", {7'b0, a20_out}, 8'h01);
      wr(1'b1, 8'hD1); wr(1'b0, 8'h01);
      chk("R8 outport A20", {6'b0, a20_out, sys_reset}, 8'h00);
      wr(1'b1, 8'hD0); rd_data(v); chk("R10 outport stored", v, 8'h01);
      wr(1'b1, 8'hD1); wr(1'b0, 8'hCF);
      chk("R8 outport A20 back", {6'b0, a20_out, sys_reset}, 8'h02);

      // R9 reset pulses
      wr(1'b1, 8'hF0); chk("R9 F0 pulse", {7'b0, sys_reset}, 8'h01);
      tick(); chk("R9 single cycle", {7'b0, sys_reset}, 8'h00);
      wr(1'b1, 8'hF1); chk("R9 F1 none", {7'b0, sys_reset}, 8'h00);
      wr(1'b1, 8'hFE); chk("R9 FE pulse", {7'b0, sys_reset}, 8'h01);
      wr(1'b1, 8'hFF); chk("R9 FF none", {7'b0, sys_reset}, 8'h00);
      wr(1'b1, 8'hD1); wr(1'b0, 8'hCE);
      chk("R9 outport pulse", {7'b0, sys_reset}, 8'h01);
      wr(1'b1, 8'hD1); wr(1'b0, 8'hCF);

      // R11 unknown command
      wr(1'b1, 8'h12);
      rd_st(v); chk("R11 status", v, exp_st(1'b0, 1'b0));
      wr(1'b1, 8'h20); rd_data(v); chk("R11 mode kept", v, 8'h03);

      // R12 drop and collision
      src(1'b1, 8'h31, 1'b0, 8'h00);
      src(1'b1, 8'h32, 1'b0, 8'h00);
      rd_data(v); chk("R12 dropped keeps first", v, 8'h31);
      rd_st(v); chk("R12 nothing left", v, exp_st(1'b0, 1'b0));
      wr(1'b1, 8'hD2);
      host_wr = 1'b1; host_addr = 1'b0; host_wdata = 8'h11;
      kbd_rx_valid = 1'b1; kbd_rx_data = 8'h22;
      tick();
      host_wr = 1'b0; kbd_rx_valid = 1'b0; cmdf = 1'b0;
      rd_data(v); chk("R12 controller byte wins", v, 8'h11);
      rd_st(v); chk("R12 source lost", v, exp_st(1'b0, 1'b0));

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule